// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the registers of a message-signalled-interrupt capability inside a device's configuration space. Software reaches it through a dword-wide configuration port: a byte address, four byte enables and write data, with read data returned combinationally for the addressed dword. The block applies a write mask to every field. It also clamps an oversized vector-count request, and it hands the decoded fields to the interrupt delivery logic: enable, enabled vector count, message address, message data, per-vector mask and pending bits.

Three build-time choices fix the layout. `IS64` adds a high address word. `PVM` adds per-vector mask and pending registers. `LOG2_MAXVEC` sets the advertised vector count. `BASE` places the structure, which must start on a dword boundary. The delivery logic sets and clears pending bits through dedicated inputs. A one-cycle strobe after each accepted software write tells it to rescan pending vectors.

Top module: `msi_cap_regs`

## Requirements
- R1: While reset is held and after its release, enable, enabled count, both address words, data, mask and pending are all zero.
- R2: The control word occupies bytes 2..3 of the structure (dword 0 bits 31:16). Bit 16 is enable, bits 19:17 the read-only capable count (`LOG2_MAXVEC`), bits 22:20 the enabled count, bit 23 the 64-bit option and bit 24 the masking option. All other bits read zero. Only enable and the enabled count change on a write.
- R3: After any accepted write that leaves enable set with an enabled count above the capable count, the enabled count holds the capable count. With enable clear, the written count is stored as is.
- R4: The low address word sits at offset 4 and its bits 1:0 are always zero. With `IS64` the high address word at offset 8 is fully writable. Without `IS64` the high half of the address output is zero.
- R5: The 16-bit data field sits at offset 8 (offset 12 with `IS64`) in bits 15:0, and all of its bits are writable. Bits 31:16 of that dword read zero.
- R6: With `PVM`, the mask register follows the data dword. Only bits 0..2^LOG2_MAXVEC-1 are writable and the rest stay zero. Without `PVM`, the mask is zero.
- R7: With `PVM`, pending sits at offset 0x10 (0x14 with `IS64`). Software writes do not change it. A `pend_clr` bit clears its vector and a `pend_set` bit sets it, and set wins when both are high. Bits at or above 2^LOG2_MAXVEC are never set.
- R8: The structure spans 0x0A, 0x0E, 0x14 or 0x18 bytes for (no option, 64-bit, masking, both). Bytes outside that span read zero and ignore writes.
- R9: A write changes only the byte lanes whose enable is set.
- R10: `wr_pulse` is high for exactly the cycle after a write with at least one enabled lane inside the structure, and low otherwise.
- R11: `cfg_rdata` reflects the addressed dword in the same cycle as the address, showing values written up to the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write request for the addressed dword |
| cfg_addr | input | AW | Configuration byte address (bits 1:0 ignored) |
| cfg_be | input | 4 | Byte lane enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed dword |
| pend_set | input | 32 | Per-vector pending set from delivery logic |
| pend_clr | input | 32 | Per-vector pending clear from delivery logic |
| msi_en | output | 1 | Message interrupts enabled |
| vec_cnt_log2 | output | 3 | log2 of the enabled vector count |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask bits |
| vec_pend | output | 32 | Per-vector pending bits |
| wr_pulse | output | 1 | One-cycle strobe after an accepted write |

## Verification
The register outputs and `wr_pulse` change one clock edge after the write or pending input is sampled. The bench therefore drives at the falling edge and compares one time unit after the next rising edge. `cfg_rdata` is combinational from the address, so it is checked after the address settles, with no edge in between. Each random step compares every output against a bench model after the edge, then moves the address to a random read location and compares read data before the next edge.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;

  localparam int VEC_MAX = 32;
  localparam int CNT_W   = 3;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CTRL,
    RG_ALO,
    RG_AHI,
    RG_DATA,
    RG_MASK,
    RG_PEND
  } reg_sel_e;

  function automatic int cap_bytes(input bit is64, input bit pvm);
    if (pvm) return is64 ? 24 : 20;
    return is64 ? 14 : 10;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] merge_w(input logic [31:0] old_v,
                                          input logic [31:0] new_v,
                                          input logic [31:0] lm,
                                          input logic [31:0] wm);
    logic [31:0] m;
    m = lm & wm;
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
`timescale 1ns/1ps
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter int AW   = 8,
  parameter int BASE = 'h50,
  parameter bit IS64 = 1'b1,
  parameter bit PVM  = 1'b1
) (
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [3:0]    cfg_be,
  output reg_sel_e      sel,
  output logic [3:0]    lane_in,
  output logic [3:0]    lane_we,
  output logic          acc
);

  localparam int SIZE = cap_bytes(IS64, PVM);
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + SIZE);

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [AW:0] ba;
    assign ba         = {1'b0, cfg_addr[AW-1:2], 2'(i)};
    assign lane_in[i] = (ba >= LO) && (ba < HI);
  end

  logic [AW-1:0] rel;
  logic [AW-3:0] didx;
  logic          hit;
  logic          unused_rel;

  assign rel        = cfg_addr - AW'(BASE);
  assign didx       = rel[AW-1:2];
  assign unused_rel = ^rel[1:0];
  assign hit        = |lane_in;

  always_comb begin
    sel = RG_NONE;
    if (hit) begin
      case (int'(didx))
        0:       sel = RG_CTRL;
        1:       sel = RG_ALO;
        2:       sel = IS64 ? RG_AHI : RG_DATA;
        3:       sel = IS64 ? RG_DATA : (PVM ? RG_MASK : RG_NONE);
        4:       sel = PVM ? (IS64 ? RG_MASK : RG_PEND) : RG_NONE;
        5:       sel = (PVM && IS64) ? RG_PEND : RG_NONE;
        default: sel = RG_NONE;
      endcase
    end
  end

  assign lane_we = {4{cfg_wr}} & cfg_be & lane_in;
  assign acc     = |lane_we;

endmodule

// File: rtl/msi_cap_ctrl.sv
`timescale 1ns/1ps
module msi_cap_ctrl #(
  parameter int LOG2_MAXVEC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       byte_we,
  input  logic [7:0] wbyte,
  output logic       en_q,
  output logic [2:0] cnt_q
);

  localparam logic [2:0] CAP = 3'(LOG2_MAXVEC);

  logic       en_d;
  logic [2:0] cnt_d;
  logic       unused_bits;

  assign unused_bits = ^{wbyte[7], wbyte[3:1]};

  always_comb begin
    en_d  = en_q;
    cnt_d = cnt_q;
    if (byte_we) begin
      en_d  = wbyte[0];
      cnt_d = wbyte[6:4];
    end
    if (en_d && (cnt_d > CAP)) cnt_d = CAP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= 3'd0;
    end else if (acc) begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  // R3
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!en_q || (cnt_q <= CAP)))
    else $error("enabled count above capable count after write");

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(en_q) && $stable(cnt_q)))
    else $error("control changed without an accepted write");

endmodule

// File: rtl/msi_cap_msg.sv
`timescale 1ns/1ps
module msi_cap_msg
  import msi_cap_pkg::*;
#(
  parameter bit IS64 = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  we_alo,
  input  logic [3:0]  we_ahi,
  input  logic [1:0]  we_data,
  input  logic [31:0] wdata,
  output logic [63:0] msg_addr,
  output logic [15:0] msg_data
);

  localparam logic [31:0] ALO_WM = 32'hFFFF_FFFC;

  logic [31:0] alo_q, alo_d;
  logic [15:0] data_q, data_d;
  logic [31:0] data_m;

  assign alo_d  = merge_w(alo_q, wdata, lane_mask(we_alo), ALO_WM);
  assign data_m = merge_w({16'h0, data_q}, wdata, lane_mask({2'b00, we_data}), 32'h0000_FFFF);
  assign data_d = data_m[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alo_q <= 32'h0;
    else if (|we_alo)    alo_q <= alo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_q <= 16'h0;
    else if (|we_data)   data_q <= data_d;
  end

  if (IS64) begin : g_hi
    logic [31:0] ahi_q, ahi_d;
    assign ahi_d = merge_w(ahi_q, wdata, lane_mask(we_ahi), 32'hFFFF_FFFF);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ahi_q <= 32'h0;
      else if (|we_ahi)  ahi_q <= ahi_d;
    end
    assign msg_addr = {ahi_q, alo_q};
  end else begin : g_nohi
    logic unused_ahi;
    assign unused_ahi = ^we_ahi;
    assign msg_addr   = {32'h0, alo_q};
  end

  // R4
  alo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_alo) |=> (msg_addr[1:0] == 2'b00))
    else $error("address low bits not zero");

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|we_data) |=> $stable(msg_data))
    else $error("data changed without a data write");

  assign msg_data = data_q;

endmodule

// File: rtl/msi_cap_vec.sv
`timescale 1ns/1ps
module msi_cap_vec
  import msi_cap_pkg::*;
#(
  parameter bit PVM         = 1'b1,
  parameter int LOG2_MAXVEC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          we_mask,
  input  logic [31:0]         wdata,
  input  logic [VEC_MAX-1:0]  pend_set,
  input  logic [VEC_MAX-1:0]  pend_clr,
  output logic [VEC_MAX-1:0]  vec_mask,
  output logic [VEC_MAX-1:0]  vec_pend
);

  localparam int          NV    = 1 << LOG2_MAXVEC;
  localparam logic [31:0] VALID = 32'hFFFF_FFFF >> (VEC_MAX - NV);

  if (PVM) begin : g_pvm
    logic [31:0] mask_q, mask_d;
    logic [31:0] pend_q, pend_d;

    assign mask_d = merge_w(mask_q, wdata, lane_mask(we_mask), VALID);
    assign pend_d = ((pend_q & ~pend_clr) | pend_set) & VALID;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= 32'h0;
      else if (|we_mask)  mask_q <= mask_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 32'h0;
      else        pend_q <= pend_d;
    end

    assign vec_mask = mask_q;
    assign vec_pend = pend_q;

    // R6
    mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|we_mask) |=> ((vec_mask & ~VALID) == 32'h0))
      else $error("mask bit set beyond vector count");

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_set & VALID)) |=>
        ((vec_pend & $past(pend_set & VALID)) == $past(pend_set & VALID)))
      else $error("pending set request lost");
  end else begin : g_nopvm
    logic unused_vec;
    assign unused_vec = ^{we_mask, wdata, pend_set, pend_clr};
    assign vec_mask   = '0;
    assign vec_pend   = '0;
  end

endmodule

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int AW          = 8,
  parameter int BASE        = 'h50,
  parameter bit IS64        = 1'b1,
  parameter bit PVM         = 1'b1,
  parameter int LOG2_MAXVEC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_addr,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [31:0]   pend_set,
  input  logic [31:0]   pend_clr,
  output logic          msi_en,
  output logic [2:0]    vec_cnt_log2,
  output logic [63:0]   msg_addr,
  output logic [15:0]   msg_data,
  output logic [31:0]   vec_mask,
  output logic [31:0]   vec_pend,
  output logic          wr_pulse
);

  localparam logic [2:0] CAP = 3'(LOG2_MAXVEC);

  reg_sel_e    sel;
  logic [3:0]  lane_in, lane_we;
  logic        acc;
  logic        pulse_q;
  logic [31:0] rmux;

  msi_cap_decode #(.AW(AW), .BASE(BASE), .IS64(IS64), .PVM(PVM)) u_dec (
    .cfg_wr  (cfg_wr),
    .cfg_addr(cfg_addr),
    .cfg_be  (cfg_be),
    .sel     (sel),
    .lane_in (lane_in),
    .lane_we (lane_we),
    .acc     (acc)
  );

  msi_cap_ctrl #(.LOG2_MAXVEC(LOG2_MAXVEC)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .byte_we((sel == RG_CTRL) && lane_we[2]),
    .wbyte  (cfg_wdata[23:16]),
    .en_q   (msi_en),
    .cnt_q  (vec_cnt_log2)
  );

  msi_cap_msg #(.IS64(IS64)) u_msg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_alo  (lane_we & {4{sel == RG_ALO}}),
    .we_ahi  (lane_we & {4{sel == RG_AHI}}),
    .we_data (lane_we[1:0] & {2{sel == RG_DATA}}),
    .wdata   (cfg_wdata),
    .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  msi_cap_vec #(.PVM(PVM), .LOG2_MAXVEC(LOG2_MAXVEC)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_mask (lane_we & {4{sel == RG_MASK}}),
    .wdata   (cfg_wdata),
    .pend_set(pend_set),
    .pend_clr(pend_clr),
    .vec_mask(vec_mask),
    .vec_pend(vec_pend)
  );

  always_comb begin
    case (sel)
      RG_CTRL: rmux = {7'h0, PVM, IS64, vec_cnt_log2, CAP, msi_en, 16'h0};
      RG_ALO:  rmux = msg_addr[31:0];
      RG_AHI:  rmux = msg_addr[63:32];
      RG_DATA: rmux = {16'h0, msg_data};
      RG_MASK: rmux = vec_mask;
      RG_PEND: rmux = vec_pend;
      default: rmux = 32'h0;
    endcase
  end

  assign cfg_rdata = rmux & lane_mask(lane_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= acc;
  end

  assign wr_pulse = pulse_q;

  // R10
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && (|cfg_be)) |=> !wr_pulse)
    else $error("strobe without a write");

  // R8
  below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cfg_addr[AW-1:2], 2'b11} < (AW+1)'(BASE)) |-> (cfg_rdata == 32'h0))
    else $error("nonzero read below the structure");

endmodule

// File: tb/sim_msi_cap_regs.sv
`timescale 1ns/1ps
module sim_msi_cap_regs;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        w_wr  [3];
  logic [7:0]  w_addr[3];
  logic [3:0]  w_be  [3];
  logic [31:0] w_dat [3];
  logic [31:0] w_ps  [3];
  logic [31:0] w_pc  [3];
  logic [31:0] rd    [3];
  logic        en    [3];
  logic [2:0]  cnt   [3];
  logic [63:0] ma    [3];
  logic [15:0] md    [3];
  logic [31:0] msk   [3];
  logic [31:0] pnd   [3];
  logic        pul   [3];

  msi_cap_regs #(.AW(8), .BASE('h50), .IS64(1'b1), .PVM(1'b1), .LOG2_MAXVEC(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(w_wr[0]), .cfg_addr(w_addr[0]), .cfg_be(w_be[0]),
    .cfg_wdata(w_dat[0]), .cfg_rdata(rd[0]), .pend_set(w_ps[0]), .pend_clr(w_pc[0]),
    .msi_en(en[0]), .vec_cnt_log2(cnt[0]), .msg_addr(ma[0]), .msg_data(md[0]),
    .vec_mask(msk[0]), .vec_pend(pnd[0]), .wr_pulse(pul[0]));

  msi_cap_regs #(.AW(8), .BASE('h40), .IS64(1'b0), .PVM(1'b1), .LOG2_MAXVEC(5)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(w_wr[1]), .cfg_addr(w_addr[1]), .cfg_be(w_be[1]),
    .cfg_wdata(w_dat[1]), .cfg_rdata(rd[1]), .pend_set(w_ps[1]), .pend_clr(w_pc[1]),
    .msi_en(en[1]), .vec_cnt_log2(cnt[1]), .msg_addr(ma[1]), .msg_data(md[1]),
    .vec_mask(msk[1]), .vec_pend(pnd[1]), .wr_pulse(pul[1]));

  msi_cap_regs #(.AW(8), .BASE('h60), .IS64(1'b0), .PVM(1'b0), .LOG2_MAXVEC(0)) u2 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(w_wr[2]), .cfg_addr(w_addr[2]), .cfg_be(w_be[2]),
    .cfg_wdata(w_dat[2]), .cfg_rdata(rd[2]), .pend_set(w_ps[2]), .pend_clr(w_pc[2]),
    .msi_en(en[2]), .vec_cnt_log2(cnt[2]), .msg_addr(ma[2]), .msg_data(md[2]),
    .vec_mask(msk[2]), .vec_pend(pnd[2]), .wr_pulse(pul[2]));

  int n_run;
  int n_fail;
  bit done;

  // bench model of u0 (64-bit, masking, 8 vectors, base 0x50)
  bit          m_en;
  logic [2:0]  m_cnt;
  logic [31:0] m_alo, m_ahi, m_mask, m_pend;
  logic [15:0] m_data;
  bit          m_acc;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] exp_rd0(input logic [7:0] a);
    logic [7:0] d;
    d = a & 8'hFC;
    if (d < 8'h50 || d >= 8'h68) return 32'h0;
    case ((d - 8'h50) >> 2)
      0: return {7'h0, 1'b1, 1'b1, m_cnt, 3'd3, m_en, 16'h0};
      1: return m_alo;
      2: return m_ahi;
      3: return {16'h0, m_data};
      4: return m_mask;
      default: return m_pend;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                          input bit wr, input logic [31:0] ps, input logic [31:0] pc);
    logic [7:0]  dw;
    logic [31:0] m;
    dw    = a & 8'hFC;
    m     = lmask(be);
    m_acc = wr && (be != 4'h0) && (dw >= 8'h50) && (dw < 8'h68);
    m_pend = ((m_pend & ~pc) | ps) & 32'hFF;
    if (m_acc) begin
      case ((dw - 8'h50) >> 2)
        0: if (be[2]) begin m_en = d[16]; m_cnt = d[22:20]; end
        1: m_alo = (m_alo & ~(m & 32'hFFFF_FFFC)) | (d & m & 32'hFFFF_FFFC);
        2: m_ahi = (m_ahi & ~m) | (d & m);
        3: m_data = (m_data & ~m[15:0]) | (d[15:0] & m[15:0]);
        4: m_mask = (m_mask & ~(m & 32'hFF)) | (d & m & 32'hFF);
        default: ;
      endcase
      if (m_en && m_cnt > 3'd3) m_cnt = 3'd3;
    end
  endtask

  task automatic step0(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                       input bit wr, input logic [31:0] ps, input logic [31:0] pc,
                       input logic [7:0] ra);
    w_wr[0] = wr; w_addr[0] = a; w_be[0] = be; w_dat[0] = d; w_ps[0] = ps; w_pc[0] = pc;
    @(posedge clk);
    #1;
    model_wr(a, be, d, wr, ps, pc);
    chk("R10 strobe", 64'(pul[0]), 64'(m_acc));
    chk("R2 enable", 64'(en[0]), 64'(m_en));
    chk("R3 count", 64'(cnt[0]), 64'(m_cnt));
    chk("R4 address", ma[0], {m_ahi, m_alo});
    chk("R5 data", 64'(md[0]), 64'(m_data));
    chk("R6 mask", 64'(msk[0]), 64'(m_mask));
    chk("R7 pending", 64'(pnd[0]), 64'(m_pend));
    w_wr[0] = 1'b0; w_addr[0] = ra; w_ps[0] = 32'h0; w_pc[0] = 32'h0;
    #1;
    chk("R11 read", 64'(rd[0]), 64'(exp_rd0(ra)));
    @(negedge clk);
  endtask

  task automatic bus(input int u, input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                     input bit wr, input logic [31:0] ps);
    w_wr[u] = wr; w_addr[u] = a; w_be[u] = be; w_dat[u] = d; w_ps[u] = ps; w_pc[u] = 32'h0;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int u, input logic [7:0] ra);
    w_wr[u] = 1'b0; w_addr[u] = ra; w_ps[u] = 32'h0; w_pc[u] = 32'h0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    for (int i = 0; i < 3; i++) begin
      w_wr[i] = 1'b0; w_addr[i] = 8'h0; w_be[i] = 4'h0; w_dat[i] = 32'h0;
      w_ps[i] = 32'h0; w_pc[i] = 32'h0;
    end
    m_en = 1'b0; m_cnt = 3'd0; m_alo = 0; m_ahi = 0; m_data = 0; m_mask = 0; m_pend = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 enable", 64'(en[0]), 64'h0);
    chk("R1 count", 64'(cnt[0]), 64'h0);
    chk("R1 address", ma[0], 64'h0);
    chk("R1 data", 64'(md[0]), 64'h0);
    chk("R1 mask", 64'(msk[0]), 64'h0);
    chk("R1 pending", 64'(pnd[0]), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    w_addr[0] = 8'h50; #1;
    chk("R2 control after reset", 64'(rd[0]), 64'h0186_0000);
    @(negedge clk);

    // R3 oversize count kept while disabled
    step0(8'h50, 4'b0100, 32'h0070_0000, 1, 0, 0, 8'h50);
    chk("R3 disabled keeps 7", 64'(cnt[0]), 64'd7);
    step0(8'h5C, 4'b0011, 32'h0000_BEEF, 1, 0, 0, 8'h5C);
    chk("R3 still 7", 64'(cnt[0]), 64'd7);
    // R3 enable with oversize count is clamped
    step0(8'h50, 4'b0100, 32'h0071_0000, 1, 0, 0, 8'h50);
    chk("R3 clamp", 64'(cnt[0]), 64'd3);
    w_addr[0] = 8'h50; #1;
    chk("R2 control word", 64'(rd[0]), 64'h01B7_0000);
    @(negedge clk);
    // R2 read-only capable count and option bits
    step0(8'h50, 4'b1100, 32'hFFFF_0000, 1, 0, 0, 8'h50);
    w_addr[0] = 8'h50; #1;
    chk("R2 read-only bits", 64'(rd[0]), 64'h01B7_0000);
    @(negedge clk);
    // R4 low address bits
    step0(8'h54, 4'hF, 32'hFFFF_FFFF, 1, 0, 0, 8'h54);
    chk("R4 low bits zero", 64'(ma[0][31:0]), 64'hFFFF_FFFC);
    // R9 lane enables
    step0(8'h5C, 4'b1100, 32'hFFFF_FFFF, 1, 0, 0, 8'h5C);
    chk("R9 data upper lanes", 64'(md[0]), 64'hBEEF);
    step0(8'h58, 4'b0010, 32'h1234_AB56, 1, 0, 0, 8'h58);
    chk("R9 single lane", 64'(ma[0][63:32]), 64'h0000_AB00);
    // R6 mask limited to 8 vectors
    step0(8'h60, 4'hF, 32'hFFFF_FFFF, 1, 0, 0, 8'h60);
    chk("R6 mask width", 64'(msk[0]), 64'hFF);
    // R7 pending
    step0(8'h64, 4'hF, 32'hFFFF_FFFF, 1, 0, 0, 8'h64);
    chk("R7 software write ignored", 64'(pnd[0]), 64'h0);
    step0(8'h48, 4'h0, 32'h0, 0, 32'h105, 0, 8'h64);
    chk("R7 set within range", 64'(pnd[0]), 64'h5);
    step0(8'h48, 4'h0, 32'h0, 0, 32'h1, 32'h1, 8'h64);
    chk("R7 set wins", 64'(pnd[0]), 64'h5);
    step0(8'h48, 4'h0, 32'h0, 0, 32'h0, 32'h4, 8'h64);
    chk("R7 clear", 64'(pnd[0]), 64'h1);
    // R8 / R10 outside the structure and empty lanes
    step0(8'h68, 4'hF, 32'hFFFF_FFFF, 1, 0, 0, 8'h68);
    chk("R10 no strobe beyond end", 64'(pul[0]), 64'h0);
    step0(8'h4C, 4'hF, 32'hFFFF_FFFF, 1, 0, 0, 8'h4C);
    chk("R8 below base ignored", 64'(pul[0]), 64'h0);
    step0(8'h54, 4'h0, 32'h0, 1, 0, 0, 8'h54);
    chk("R10 no strobe without lanes", 64'(pul[0]), 64'h0);

    // random traffic on u0
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a, ra;
      logic [31:0] ps;
      a  = 8'h48 + 8'($urandom % 36);
      ra = 8'h44 + 8'($urandom % 44);
      ps = $urandom & $urandom & $urandom;
      step0(a, 4'($urandom), $urandom, ($urandom % 4) != 0, ps, $urandom, ra);
    end

    // u1: 32-bit layout with masking, 32 vectors, base 0x40
    idle(1, 8'h40);
    chk("R2 control 32-bit", 64'(rd[1]), 64'h010A_0000);
    @(negedge clk);
    bus(1, 8'h48, 4'hF, 32'hAAAA_1234, 1, 0);
    chk("R5 data at 0x08", 64'(md[1]), 64'h1234);
    chk("R4 no high word", 64'(ma[1][63:32]), 64'h0);
    idle(1, 8'h48);
    chk("R5 data upper reads zero", 64'(rd[1]), 64'h0000_1234);
    @(negedge clk);
    bus(1, 8'h4C, 4'hF, 32'hFFFF_FFFF, 1, 0);
    chk("R6 full mask", 64'(msk[1]), 64'hFFFF_FFFF);
    @(negedge clk);
    bus(1, 8'h40, 4'h0, 32'h0, 0, 32'h8000_0001);
    idle(1, 8'h50);
    chk("R7 pending at 0x10", 64'(rd[1]), 64'h8000_0001);
    w_addr[1] = 8'h54; #1;
    chk("R8 beyond 0x14 zero", 64'(rd[1]), 64'h0);
    @(negedge clk);

    // u2: no options, single vector, base 0x60
    bus(2, 8'h68, 4'hF, 32'hFFFF_FFFF, 1, 0);
    chk("R8 strobe inside 0x0A", 64'(pul[2]), 64'h1);
    idle(2, 8'h68);
    chk("R8 half dword span", 64'(rd[2]), 64'h0000_FFFF);
    w_addr[2] = 8'h6C; #1;
    chk("R8 beyond 0x0A zero", 64'(rd[2]), 64'h0);
    @(negedge clk);
    bus(2, 8'h6C, 4'hF, 32'hFFFF_FFFF, 1, 0);
    chk("R10 no strobe past end", 64'(pul[2]), 64'h0);
    chk("R6 no mask without option", 64'(msk[2]), 64'h0);
    @(negedge clk);
    bus(2, 8'h60, 4'b0100, 32'h0021_0000, 1, 0);
    chk("R3 clamp to single vector", 64'(cnt[2]), 64'h0);
    chk("R3 enable set", 64'(en[2]), 64'h1);
    idle(2, 8'h60);
    chk("R2 control no options", 64'(rd[2]), 64'h0001_0000);
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule